// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Free-Running Timebase

This block is a memory-mapped watchdog for a processor subsystem. A simple 32-bit register port carries a word address, a write strobe, write data and combinational read data. A timebase counter runs without stopping from the moment reset is released. Software can read it to confirm that the clock is alive and to measure elapsed time.

The watchdog interval is 2^N clocks, where N is a parameter. When the interval runs out for the first time, the block sets a timer-state flag and holds its interrupt output high. If the interval runs out again before software services the timer, the block sets a reset-status flag and drives a system reset pulse of fixed length. Software services the timer by writing 1 to either flag bit. That write clears the flag and starts a new interval. The counter runs while at least one of two enable keys is set. The keys sit in two different registers, so stopping the timer takes two deliberate writes. An enable-once parameter removes the ability to clear the keys at all.

The reset-status flag is kept through the system reset that the block itself causes, so software can see after the restart why the restart happened. Only the power-on reset input or a write of 1 to the flag clears it.

Top module: `wdt_twostage`

## Requirements
- R1: After power-on reset, control/status 0 (offset 0x0) and control/status 1 (offset 0x4) read as zero, and both the interrupt and the reset output are low.
- R2: The timebase register at offset 0x8 increases by one every clock. Writes to offset 0x8 do not change it.
- R3: Once an enable key is set, the timer-state flag (bit 2 of offset 0x0) sets exactly 2^N clocks after the enabling write. The interrupt output equals that flag.
- R4: If the interval runs out again while the timer-state flag is still set, the reset-status flag (bit 3 of offset 0x0) sets and the reset output is high for exactly 16 consecutive clocks.
- R5: Writing 1 to bit 2 or bit 3 of offset 0x0 clears that flag and restarts the interval from zero. A service write that lands in the same cycle as an expiry takes priority over the expiry.
- R6: The timer counts while enable key 1 (bit 1 of offset 0x0) or enable key 2 (bit 0 of offset 0x4) is set. With both keys clear, it holds at zero and never expires.
- R7: With the enable-once parameter set, writes cannot clear an enable key once it has been set, so the timer keeps running.
- R8: The system reset input clears the keys, the timer-state flag, the interval counter and the timebase, but leaves the reset-status flag as it was. Power-on reset clears everything.
- R9: Offset 0x4 reads the value of enable key 2 in bit 0. Reads of any offset other than 0x0, 0x4 and 0x8 return zero.
- R10: Writing 0 to bit 2 or bit 3 of offset 0x0 leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n | input | 1 | System reset, active low, synchronous; keeps the reset-status flag |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wdt_irq | output | 1 | Interrupt, high while the timer-state flag is set |
| wdt_rst | output | 1 | System reset request pulse, active high |

## Verification
The assertions check the following on every cycle:
- A rising reset output is always preceded by the reset-status flag.
- The reset-status flag only sets while the timer-state flag is already set.
- Every reset pulse ends after exactly 16 clocks.
- With both keys clear, no new expiry appears.
- The timebase always moves.
- The reset-status flag survives a system reset.
- The keys never drop when enable-once is set.

Only the bench scenarios can show the following:
- The exact cycle at which each expiry lands after an enabling or service write.
- That writes of 0 to the flag bits and writes to the timebase are ignored.
- The read decoding of unmapped offsets.
- That either key on its own keeps the timer running.

// File: rtl/wdt_twostage_pkg.sv
package wdt_twostage_pkg;

    // Byte offsets on the register port
    localparam int unsigned OFS_CTRL0 = 0;
    localparam int unsigned OFS_CTRL1 = 4;
    localparam int unsigned OFS_TBASE = 8;

    // Bit positions that software relies on
    localparam int unsigned BIT_RFLAG = 3;
    localparam int unsigned BIT_STATE = 2;
    localparam int unsigned BIT_KEY1  = 1;
    localparam int unsigned BIT_KEY2  = 0;

    typedef struct packed {
        logic key1;
        logic key2;
        logic state;
        logic rflag;
    } wdt_ctl_t;

    localparam wdt_ctl_t CTL_CLEAR = '{key1: 1'b0, key2: 1'b0, state: 1'b0, rflag: 1'b0};

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + WIDTH'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.count;

endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
    parameter int unsigned LOG2_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);

    localparam logic [LOG2_LEN-1:0] LAST = '1;

    typedef struct packed {
        logic [LOG2_LEN-1:0] count;
    } iv_state_t;

    iv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || restart) st_d.count = '0;
        else                 st_d.count = st_q.count + LOG2_LEN'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A service write in the same cycle suppresses the expiry
    assign expire = run && !restart && (st_q.count == LAST);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned LENGTH = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic fire,
    output logic active
);

    localparam int unsigned CW = $clog2(LENGTH + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } pl_state_t;

    pl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0)  st_d.left = st_q.left - CW'(1);
        else if (fire)        st_d.left = CW'(LENGTH);
    end

    // Only power-on reset clears it, so the pulse survives its own reset
    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.left != '0);

endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_twostage_pkg::*;
#(
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned TB_W          = 32,
    parameter int unsigned INTERVAL_LOG2 = 16,
    parameter int unsigned RST_PULSE     = 16,
    parameter bit          ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst
);

    localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(OFS_CTRL0);
    localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFS_CTRL1);
    localparam logic [ADDR_W-1:0] A_TBASE = ADDR_W'(OFS_TBASE);

    logic            rst_all_n;
    logic            wr_ctrl0, wr_ctrl1;
    logic            kick, run, expire, fire;
    logic [TB_W-1:0] tb_value;
    wdt_ctl_t        ctl_d, ctl_q;

    assign rst_all_n = por_n & rst_n;
    assign wr_ctrl0  = bus_we && (bus_addr == A_CTRL0);
    assign wr_ctrl1  = bus_we && (bus_addr == A_CTRL1);
    assign kick      = wr_ctrl0 && (bus_wdata[BIT_RFLAG] || bus_wdata[BIT_STATE]);
    assign run       = ctl_q.key1 || ctl_q.key2;

    wdt_timebase #(.WIDTH(TB_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_all_n),
        .value (tb_value)
    );

    wdt_interval #(.LOG2_LEN(INTERVAL_LOG2)) u_interval (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .run     (run),
        .restart (kick),
        .expire  (expire)
    );

    wdt_pulse #(.LENGTH(RST_PULSE)) u_pulse (
        .clk    (clk),
        .por_n  (por_n),
        .fire   (fire),
        .active (wdt_rst)
    );

    assign fire = expire && ctl_q.state && rst_n;

    always_comb begin
        ctl_d = ctl_q;
        // Expiry: first sets the state flag, second sets the reset flag
        if (expire) begin
            if (ctl_q.state) ctl_d.rflag = 1'b1;
            else             ctl_d.state = 1'b1;
        end
        // Register writes take priority over an expiry
        if (wr_ctrl0) begin
            if (bus_wdata[BIT_RFLAG]) ctl_d.rflag = 1'b0;
            if (bus_wdata[BIT_STATE]) ctl_d.state = 1'b0;
            if (ENABLE_ONCE) ctl_d.key1 = ctl_q.key1 | bus_wdata[BIT_KEY1];
            else             ctl_d.key1 = bus_wdata[BIT_KEY1];
        end
        if (wr_ctrl1) begin
            if (ENABLE_ONCE) ctl_d.key2 = ctl_q.key2 | bus_wdata[BIT_KEY2];
            else             ctl_d.key2 = bus_wdata[BIT_KEY2];
        end
        // System reset keeps only the reset-status flag
        if (!rst_n) begin
            ctl_d       = CTL_CLEAR;
            ctl_d.rflag = ctl_q.rflag;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) ctl_q <= CTL_CLEAR;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL0: begin
                bus_rdata[BIT_RFLAG] = ctl_q.rflag;
                bus_rdata[BIT_STATE] = ctl_q.state;
                bus_rdata[BIT_KEY1]  = ctl_q.key1;
            end
            A_CTRL1: bus_rdata[BIT_KEY2] = ctl_q.key2;
            A_TBASE: bus_rdata = DATA_W'(tb_value);
            default: bus_rdata = '0;
        endcase
    end

    assign wdt_irq = ctl_q.state;

endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
    parameter int unsigned TB_W        = 32,
    parameter int unsigned RST_PULSE   = 16,
    parameter bit          ENABLE_ONCE = 1'b0
) (
    input logic            clk,
    input logic            por_n,
    input logic            rst_n,
    input logic            key1,
    input logic            key2,
    input logic            state,
    input logic            rflag,
    input logic            rst_out,
    input logic [TB_W-1:0] tb
);

    localparam int unsigned HW = $clog2(RST_PULSE + 2);

    logic [HW-1:0] high_q;

    always_ff @(posedge clk) begin
        if (!por_n)       high_q <= '0;
        else if (rst_out) high_q <= high_q + HW'(1);
        else              high_q <= '0;
    end

    AST_PULSE_NEEDS_RFLAG: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out) |-> rflag);  // R4

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> (high_q == HW'(RST_PULSE)));  // R4

    AST_SECOND_STAGE_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rflag) |-> $past(state));  // R4

    AST_STOPPED_NO_EXPIRY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!key1 && !key2 && !state) |=> !state);  // R6

    AST_TIMEBASE_MOVES: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (por_n && rst_n) |=> (tb != $past(tb)));  // R2

    AST_RFLAG_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(rst_n) && $past(rflag)) |-> rflag);  // R8

    generate
        if (ENABLE_ONCE) begin : g_once
            AST_KEYS_STICK: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
                ($past(rst_n) && $past(key1 || key2)) |-> (key1 || key2));  // R7
        end
    endgenerate

endmodule

bind wdt_twostage wdt_twostage_chk #(
    .TB_W        (TB_W),
    .RST_PULSE   (RST_PULSE),
    .ENABLE_ONCE (ENABLE_ONCE)
) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .key1    (ctl_q.key1),
    .key2    (ctl_q.key2),
    .state   (ctl_q.state),
    .rflag   (ctl_q.rflag),
    .rst_out (wdt_rst),
    .tb      (tb_value)
);

// File: tb/wdt_twostage_bench.sv
module wdt_twostage_bench;

    localparam int unsigned LOG2 = 6;
    localparam int unsigned IV   = 1 << LOG2;
    localparam int unsigned PULSE = 16;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b, rst_a, rst_b;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_twostage #(.INTERVAL_LOG2(LOG2), .RST_PULSE(PULSE)) u_wdt_twostage (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_a),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .wdt_irq(irq_a), .wdt_rst(rst_a)
    );

    wdt_twostage #(.INTERVAL_LOG2(LOG2), .RST_PULSE(PULSE), .ENABLE_ONCE(1'b1)) u_once (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_b),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .wdt_irq(irq_b), .wdt_rst(rst_b)
    );

    function automatic bit exp_expired(input int unsigned gap);
        return gap >= IV;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel_b, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        if (sel_b) we_b = 1'b1; else we_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
    endtask

    task automatic rd(input bit sel_b, input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = sel_b ? rdata_b : rdata_a;
    endtask

    task automatic idle(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, t1, t2, t3;
        int unsigned cnt;
        void'($urandom(32'd7351));

        repeat (4) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 4'h0, v); check(v == 0, "R1", v, 0);
        rd(0, 4'h4, v); check(v == 0, "R1", v, 0);
        check(!irq_a && !rst_a, "R1", {irq_a, rst_a}, 0);
        rd(1, 4'h0, v); check(v == 0, "R1", v, 0);

        // R2 timebase
        rd(0, 4'h8, t1);
        @(negedge clk);
        rd(0, 4'h8, t2);
        check(t2 == t1 + 1, "R2", t2, t1 + 1);
        wr(0, 4'h8, 32'hFFFF0000);
        rd(0, 4'h8, t3);
        check((t3 - t2) >= 1 && (t3 - t2) <= 8, "R2", t3, t2 + 2);

        // R9 unmapped offsets
        foreach (t1[i]) if (i < 4) begin
            logic [3:0] ua;
            ua = (i == 0) ? 4'hC : (i == 1) ? 4'h1 : (i == 2) ? 4'h6 : 4'hF;
            rd(0, ua, v); check(v == 0, "R9", v, 0);
        end

        // R3 first expiry
        wr(0, 4'h0, 32'h2);
        idle(IV - 1);
        check(!irq_a, "R3", irq_a, 0);
        idle(1);
        check(irq_a, "R3", irq_a, 1);
        rd(0, 4'h0, v); check(v == 32'h6, "R3", v, 32'h6);

        // R5 keepalive with random and boundary gaps
        wr(0, 4'h0, 32'h6);
        check(!irq_a, "R5", irq_a, 0);
        for (int i = 0; i < 10; i++) begin
            int unsigned gap;
            gap = (i == 0) ? IV - 1 : (i == 1) ? IV : $urandom_range(2 * IV - 1, 1);
            idle(gap);
            check(irq_a == exp_expired(gap), "R5", irq_a, exp_expired(gap));
            check(!rst_a, "R5", rst_a, 0);
            wr(0, 4'h0, (i % 2 == 0) ? 32'h6 : 32'hA);
            if (i % 2 == 1 && exp_expired(gap)) wr(0, 4'h0, 32'h6);
        end

        // R4 second expiry and pulse length
        wr(0, 4'h0, 32'h6);
        idle(2 * IV - 1);
        check(!rst_a && irq_a, "R4", {irq_a, rst_a}, 32'h2);
        rd(0, 4'h0, v); check(v == 32'h6, "R4", v, 32'h6);
        idle(1);
        check(rst_a, "R4", rst_a, 1);
        rd(0, 4'h0, v); check(v == 32'hE, "R4", v, 32'hE);
        cnt = 0;
        while (rst_a && cnt < 40) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == PULSE, "R4", cnt, PULSE);

        // R10 writing zero to the flags
        wr(0, 4'h0, 32'h2);
        rd(0, 4'h0, v); check(v == 32'hE, "R10", v, 32'hE);

        // R8 system reset keeps the reset-status flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(0, 4'h0, v); check(v == 32'h8, "R8", v, 32'h8);
        check(!irq_a, "R8", irq_a, 0);
        rd(0, 4'h8, v); check(v <= 2, "R8", v, 1);
        wr(0, 4'h0, 32'h8);
        rd(0, 4'h0, v); check(v == 0, "R8", v, 0);

        // R6 key 2 alone runs the timer, both clear stops it
        wr(0, 4'h4, 32'h1);
        rd(0, 4'h4, v); check(v == 1, "R9", v, 1);
        idle(IV);
        check(irq_a, "R6", irq_a, 1);
        wr(0, 4'h0, 32'h6);
        wr(0, 4'h0, 32'h4);
        idle(IV);
        check(irq_a, "R6", irq_a, 1);
        wr(0, 4'h0, 32'h4);
        wr(0, 4'h4, 32'h0);
        idle(3 * IV);
        check(!irq_a && !rst_a, "R6", {irq_a, rst_a}, 0);
        rd(0, 4'h0, v); check(v == 0, "R6", v, 0);

        // R7 enable-once instance cannot be stopped
        wr(1, 4'h0, 32'h2);
        wr(1, 4'h0, 32'h0);
        wr(1, 4'h4, 32'h0);
        rd(1, 4'h0, v); check(v == 32'h2, "R7", v, 32'h2);
        idle(IV);
        check(irq_b, "R7", irq_b, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule